// File: doc/BRIEF.md
# Eight-pin GPIO port register block

This block is the register file of one 8-pin general-purpose I/O port. A simple memory-mapped bus reaches it: a byte address, write data, a write strobe and combinational read data. Three writable per-pin registers control the port: a configuration enable that hands the pin to the GPIO function, an output enable, and an output value. A fourth, read-only register returns the pad levels after a two-flop synchronizer.

Each writable register can be reached through two addresses. A direct write replaces all eight bits. A masked write uses its upper byte as a per-pin select and its lower byte as the new values, so software can change one pin without a read-modify-write sequence. The pad output enable is asserted for a pin only when both its configuration bit and its output-enable bit are set. This lets software load the output value first and then enable the driver, so the pin never drives a stale level.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the configuration, output-enable and output-value registers read 0x00 and `pad_oe_o` is 0.
- R2: A direct write (configuration 0x000, output enable 0x010, output value 0x020) loads wdata bits 7:0 into all eight register bits and ignores the higher wdata bits.
- R3: A masked write (configuration 0x800, output enable 0x810, output value 0x820) sets register bit i to wdata bit i where wdata bit 8+i is 1, and leaves the other bits unchanged.
- R4: A masked write whose bits 15:8 are all 0 leaves the register unchanged.
- R5: A read of any mapped address returns the register value in bits 7:0 and 0 in bits 31:8. Masked aliases return the same value as their direct address.
- R6: The input register at 0x030 returns the pad level of pin i in bit i, two clock edges after the pad changes. Writes to 0x030 have no effect.
- R7: `pad_oe_o[i]` is 1 exactly when configuration bit i and output-enable bit i are both 1. `pad_out_o` is the output-value register.
- R8: Pad outputs change on the clock edge that completes the write, never during the write cycle. After an output value is loaded and the configuration bit is then set, the pad value is already correct when its enable rises.
- R9: Unmapped addresses read as 0, and writes to them change no register.
- R10: A write through one register's address leaves the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address within the port |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pad_in_i | input | 8 | Pad input levels, asynchronous |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
The bench exercises masked writes with partial selects, with an empty select, and with selects that clear some bits and set others. A design that treated the select as a value, or that wrote unselected bits, would return a wrong read-back. It writes 0x030 and an unmapped address and reads every register back afterwards, which catches a decoder that aliases on partial address bits or lets software write the input register. It samples the input register one and two edges after a pad change, which catches a missing or extra synchronizer stage. It also follows the output-then-enable sequence at the pads, which catches an output enable that ignores the configuration bit or that leaks combinationally from the bus.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_CFG = 2'd0,
    SEL_OE  = 2'd1,
    SEL_OUT = 2'd2,
    SEL_IN  = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_WR_REGS = 3;
  localparam int unsigned ALIAS_BIT   = 11;  // 0x800 selects the masked alias
  localparam int unsigned SEL_LSB     = 4;   // 0x10 stride between registers
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              masked_o,
  output reg_sel_e          sel_o
);
  logic [ADDR_W-1:0] fixed_bits;

  always_comb begin
    fixed_bits            = addr_i;
    fixed_bits[ALIAS_BIT] = 1'b0;
    fixed_bits[SEL_LSB+1:SEL_LSB] = 2'b00;
    masked_o = addr_i[ALIAS_BIT];
    sel_o    = reg_sel_e'(addr_i[SEL_LSB+1:SEL_LSB]);
    // the input register has no masked alias
    hit_o    = (fixed_bits == '0) && !(masked_o && sel_o == SEL_IN);
  end
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int unsigned NPINS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               masked_i,
  input  logic [2*NPINS-1:0] data_i,
  output logic [NPINS-1:0]   q_o
);
  logic [NPINS-1:0] sel, val, nxt;

  assign val = data_i[NPINS-1:0];
  assign sel = masked_i ? data_i[2*NPINS-1:NPINS] : '1;

  always_comb nxt = (q_o & ~sel) | (val & sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= nxt;
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
  p_direct_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !masked_i) |=> (q_o == $past(data_i[NPINS-1:0])));
  p_mask_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && masked_i) |=>
      (((q_o ^ $past(q_o)) & ~$past(data_i[2*NPINS-1:NPINS])) == '0));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] d_i,
  output logic [NPINS-1:0] q_o
);
  logic [NPINS-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end

  // cycles since reset, for the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o
);
  localparam int unsigned WR_W = 2 * NPINS;

  logic     hit, masked;
  reg_sel_e sel;
  logic [NPINS-1:0] regs [NUM_WR_REGS];
  logic [NPINS-1:0] in_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:WR_W];

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i  (addr_i),
    .hit_o   (hit),
    .masked_o(masked),
    .sel_o   (sel)
  );

  for (genvar g = 0; g < NUM_WR_REGS; g++) begin : g_reg
    gpio_mask_reg #(.NPINS(NPINS)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i && hit && (sel == reg_sel_e'(g))),
      .masked_i(masked),
      .data_i  (wdata_i[WR_W-1:0]),
      .q_o     (regs[g])
    );
  end

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (in_q)
  );

  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o[NPINS-1:0] = (sel == SEL_IN) ? in_q : regs[sel];
  end

  assign pad_out_o = regs[SEL_OUT];
  assign pad_oe_o  = regs[SEL_CFG] & regs[SEL_OE];

  always_comb begin
    p_rdata_upper_r5: assert (rdata_o[DATA_W-1:NPINS] == '0);
  end
endmodule

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic [7:0]  pad_in_i = '0;
  logic [7:0]  pad_out_o, pad_oe_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  gpio_port_regs uut (.*);

  // {is_write, addr, wdata, expected read byte}
  localparam int NV = 18;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'hFFFF_FF5A, 8'h00},  // R2 upper ignored
    {1'b0, 12'h000, 32'h0,         8'h5A},
    {1'b1, 12'h820, 32'h0000_0F0A, 8'h00},  // R3
    {1'b0, 12'h020, 32'h0,         8'h0A},
    {1'b1, 12'h820, 32'h0000_C0FF, 8'h00},  // R3
    {1'b0, 12'h820, 32'h0,         8'hCA},  // R5 alias read
    {1'b1, 12'h820, 32'h0000_00FF, 8'h00},  // R4 empty mask
    {1'b0, 12'h020, 32'h0,         8'hCA},
    {1'b1, 12'h800, 32'h0000_0300, 8'h00},  // R3 clear
    {1'b0, 12'h000, 32'h0,         8'h58},
    {1'b1, 12'h010, 32'h0000_003C, 8'h00},
    {1'b1, 12'h810, 32'h0000_8181, 8'h00},
    {1'b0, 12'h810, 32'h0,         8'hBD},
    {1'b1, 12'h030, 32'h0000_00FF, 8'h00},  // R6 read-only
    {1'b0, 12'h030, 32'h0,         8'h00},
    {1'b1, 12'h040, 32'h0000_FFFF, 8'h00},  // R9 unmapped
    {1'b0, 12'h040, 32'h0,         8'h00},
    {1'b0, 12'h000, 32'h0,         8'h58}   // R10 untouched
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [7:0] exp);
    addr_i = a;
    #2;
    check(req, rdata_o, {24'h0, exp});
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd("R1", 12'h000, 8'h00);
    rd("R1", 12'h010, 8'h00);
    rd("R1", 12'h020, 8'h00);
    check("R1", {24'h0, pad_oe_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][52]) wr(VEC[i][51:40], VEC[i][39:8]);
      else            rd("R2-R5/R9 vector", VEC[i][51:40], VEC[i][7:0]);
    end
    rd("R10", 12'h010, 8'hBD);
    rd("R10", 12'h020, 8'hCA);

    // R7 gate: cfg 58 & oe BD
    check("R7", {24'h0, pad_oe_o}, 32'h18);
    check("R7", {24'h0, pad_out_o}, 32'hCA);

    // R8 output value first, then configuration
    @(negedge clk_i);
    addr_i = 12'h820; wdata_i = 32'h0000_0101; we_i = 1'b1;
    #2 check("R8 no change mid-write", {24'h0, pad_out_o}, 32'hCA);
    @(negedge clk_i); we_i = 1'b0;
    check("R8", {24'h0, pad_out_o}, 32'hCB);
    check("R8", {24'h0, pad_oe_o}, 32'h18);
    wr(12'h800, 32'h0000_0101);
    check("R8", {24'h0, pad_oe_o}, 32'h19);
    check("R8", {24'h0, pad_out_o}, 32'hCB);

    // R6 synchronizer latency
    @(negedge clk_i);
    pad_in_i = 8'hA5;
    @(negedge clk_i);
    rd("R6 one edge", 12'h030, 8'h00);
    @(negedge clk_i);
    rd("R6 two edges", 12'h030, 8'hA5);
    wr(12'h030, 32'h0000_0000);
    rd("R6 write ignored", 12'h030, 8'hA5);

    // R1 reset in mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd("R1 rerun", 12'h020, 8'h00);
    check("R1 rerun", {24'h0, pad_oe_o}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule